// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupts for a small 8-bit processor core. Three request sources feed it: a synchronized edge from an external pin and an overflow pulse from each of two timer/event counters. Each source has a sticky request flag and an enable bit. Together with a master enable, these sit in one 8-bit control/status word that the core reads and writes over a simple register port.

Once per instruction cycle, a sampling strobe selects the most urgent source that may be serviced. The block then raises a call request that carries that source's vector address. When the core accepts the call, the block clears the serviced flag and the master enable, so handlers do not nest. A return-from-interrupt turns the master enable back on. A plain subroutine return leaves it alone. No request is taken while the core's call stack is full.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0x00 and callReq is low.
- R2: Word layout: bit0 master enable, bit1 external enable, bit2 timer-0 enable, bit3 timer-1 enable, bit4 external flag, bit5 timer-0 flag, bit6 timer-1 flag. A write loads bits 6..0, including the flags, so software can force or cancel a request. Bit7 always reads 0.
- R3: A set event (extEdge, tmr0Ovf, tmr1Ovf) sets its flag, and the flag stays set. A set event wins over a write that clears the same flag in the same cycle.
- R4: A source is eligible only if the master enable, its own enable and its flag are all set and stackFull is low. Eligibility is evaluated only in a cycle where sampleStb is high.
- R5: Among eligible sources the external one wins, then timer 0, then timer 1. The vectors are 0x04, 0x08 and 0x0C. Requests that arrive between two strobes are resolved together at the later strobe.
- R6: callReq and callVector hold steady until callAck. callReq drops as soon as the master enable is cleared, and it stays low until a later strobe.
- R7: callAck while callReq is high clears the serviced flag and the master enable and leaves the other bits unchanged. callAck while callReq is low has no effect.
- R8: rtnStb with rtnIsReti high sets the master enable.
- R9: rtnStb with rtnIsReti low changes nothing.
- R10: Clearing enables never erases a pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | Instruction-cycle sampling strobe |
| regWrEn | input | 1 | Control word write enable |
| regWrData | input | 8 | Control word write data |
| regRdData | output | 8 | Control word read data |
| extEdge | input | 1 | Synchronized external edge pulse |
| tmr0Ovf | input | 1 | Timer 0 overflow pulse |
| tmr1Ovf | input | 1 | Timer 1 overflow pulse |
| stackFull | input | 1 | Core call stack is full |
| rtnStb | input | 1 | Core executed a return |
| rtnIsReti | input | 1 | The return is a return-from-interrupt |
| callAck | input | 1 | Core accepts the call request |
| callReq | output | 1 | Vectored call request |
| callVector | output | 8 | Vector address of the call |

## Verification
The hardest situation to reach is a call that is already pending and has not been acknowledged when software drops the master enable. The request has to vanish and must not come back when the enable is restored. The bench gets there by raising a call, writing the word with bit0 cleared while callAck stays low, and then writing the old value back. It then checks that no request appears until the next strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_CNT = 3;

  typedef struct packed {
    logic               ackClr;
    logic [SRC_CNT-1:0] ackSel;
  } irqStrobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int DW = 8,
  parameter int N  = SRC_CNT
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  input  logic [N-1:0]  setEvt,
  input  logic          rtnStb,
  input  logic          rtnIsReti,
  input  irqStrobe_t    ctl,
  output logic          masterEn,
  output logic [N-1:0]  srcEn,
  output logic [N-1:0]  srcFlag,
  output logic [DW-1:0] regRdData
);
  localparam int EN_LO = 1;
  localparam int FL_LO = N + 1;
  localparam int USED  = 2 * N + 1;

  logic          meNext;
  logic [N-1:0]  enNext;
  logic [N-1:0]  flNext;
  logic          wrUnused;

  assign wrUnused = ^regWrData[DW-1:USED];

  always_comb begin
    meNext = masterEn;
    enNext = srcEn;
    flNext = srcFlag;
    if (regWrEn) begin
      meNext = regWrData[0];
      enNext = regWrData[EN_LO +: N];
      flNext = regWrData[FL_LO +: N];
    end
    if (rtnStb && rtnIsReti) meNext = 1'b1;
    if (ctl.ackClr) begin
      meNext = 1'b0;
      flNext = flNext & ~ctl.ackSel;
    end
    flNext = flNext | setEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterEn <= 1'b0;
      srcEn    <= '0;
      srcFlag  <= '0;
    end else begin
      masterEn <= meNext;
      srcEn    <= enNext;
      srcFlag  <= flNext;
    end
  end

  always_comb begin
    regRdData             = '0;
    regRdData[0]          = masterEn;
    regRdData[EN_LO +: N] = srcEn;
    regRdData[FL_LO +: N] = srcFlag;
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int N        = SRC_CNT,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleStb,
  input  logic          stackFull,
  input  logic          callAck,
  input  logic          masterEn,
  input  logic [N-1:0]  srcEn,
  input  logic [N-1:0]  srcFlag,
  output logic          callReq,
  output logic [DW-1:0] callVector,
  output irqStrobe_t    ctl
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  elig;
  logic [SW-1:0] win;
  logic          pend;
  logic [SW-1:0] srcIdx;
  logic          ackOk;

  assign elig = srcEn & srcFlag & {N{masterEn & ~stackFull}};

  // lowest index = highest priority
  always_comb begin
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) win = SW'(i);
    end
  end

  assign callReq    = pend & masterEn;
  assign callVector = DW'(VEC_BASE + int'(srcIdx) * VEC_STEP);
  assign ackOk      = callReq & callAck;

  always_comb begin
    ctl.ackClr = ackOk;
    ctl.ackSel = '0;
    if (ackOk) ctl.ackSel[srcIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend   <= 1'b0;
      srcIdx <= '0;
    end else if (ackOk || !masterEn) begin
      pend <= 1'b0;
    end else if (!pend && sampleStb && (|elig)) begin
      pend   <= 1'b1;
      srcIdx <= win;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int DW       = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleStb,
  input  logic          regWrEn,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic          extEdge,
  input  logic          tmr0Ovf,
  input  logic          tmr1Ovf,
  input  logic          stackFull,
  input  logic          rtnStb,
  input  logic          rtnIsReti,
  input  logic          callAck,
  output logic          callReq,
  output logic [DW-1:0] callVector
);
  localparam int N = SRC_CNT;

  irqStrobe_t   ctl;
  logic         masterEn;
  logic [N-1:0] srcEn;
  logic [N-1:0] srcFlag;

  irq_datapath #(.DW(DW), .N(N)) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .setEvt({tmr1Ovf, tmr0Ovf, extEdge}),
    .rtnStb(rtnStb), .rtnIsReti(rtnIsReti),
    .ctl(ctl),
    .masterEn(masterEn), .srcEn(srcEn), .srcFlag(srcFlag),
    .regRdData(regRdData)
  );

  irq_control #(.DW(DW), .N(N), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_ctl (
    .clk(clk), .rstN(rstN),
    .sampleStb(sampleStb), .stackFull(stackFull), .callAck(callAck),
    .masterEn(masterEn), .srcEn(srcEn), .srcFlag(srcFlag),
    .callReq(callReq), .callVector(callVector), .ctl(ctl)
  );
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sampleStb,
  input logic       regWrEn,
  input logic [7:0] regRdData,
  input logic       tmr0Ovf,
  input logic       stackFull,
  input logic       rtnStb,
  input logic       rtnIsReti,
  input logic       callAck,
  input logic       callReq,
  input logic [7:0] callVector
);
  p_bit7_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[7] == 1'b0);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    tmr0Ovf |=> regRdData[5]);

  p_stack_block_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && stackFull && !callReq) |=> !callReq);

  p_vector_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> (callVector == 8'h04 || callVector == 8'h08 || callVector == 8'h0C));

  p_call_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && !callAck && !regWrEn) |=> (callReq && $stable(callVector)));

  p_ack_clears_me_r7: assert property (@(posedge clk) disable iff (!rstN)
    (callReq && callAck) |=> !regRdData[0]);

  p_reti_sets_me_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rtnStb && rtnIsReti && !(callReq && callAck)) |=> regRdData[0]);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[4] && !regWrEn && !(callReq && callAck)) |=> regRdData[4]);
endmodule

bind prio_irq_ctrl irq_ctrl_checker u_chk (.*);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleStb = 1'b0, regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       extEdge = 1'b0, tmr0Ovf = 1'b0, tmr1Ovf = 1'b0;
  logic       stackFull = 1'b0, rtnStb = 1'b0, rtnIsReti = 1'b0, callAck = 1'b0;
  logic       callReq;
  logic [7:0] callVector;
  int nChk = 0, nFail = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; #1;
  endtask

  task automatic strobe;
    @(negedge clk); sampleStb = 1'b1;
    @(negedge clk); sampleStb = 1'b0; #1;
  endtask

  task automatic ack;
    @(negedge clk); callAck = 1'b1;
    @(negedge clk); callAck = 1'b0; #1;
  endtask

  task automatic rtn(input logic isReti);
    @(negedge clk); rtnStb = 1'b1; rtnIsReti = isReti;
    @(negedge clk); rtnStb = 1'b0; rtnIsReti = 1'b0; #1;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    extEdge = (which == 0); tmr0Ovf = (which == 1); tmr1Ovf = (which == 2);
    @(negedge clk); extEdge = 1'b0; tmr0Ovf = 1'b0; tmr1Ovf = 1'b0; #1;
  endtask

  task automatic t_reset;
    chk("R1 word", regRdData, 8'h00);
    chk("R1 callReq", {7'd0, callReq}, 8'h00);
  endtask

  task automatic t_regmap;
    wr(8'hFF); chk("R2 bit7 reads 0", regRdData, 8'h7F);
    wr(8'h00); chk("R2 clear", regRdData, 8'h00);
  endtask

  task automatic t_sticky;
    pulse(2);
    stepN(3); chk("R3 flag sticky", regRdData, 8'h40);
    strobe; chk("R10 masked no call", {7'd0, callReq}, 8'h00);
    chk("R10 flag kept", regRdData, 8'h40);
    @(negedge clk); regWrEn = 1'b1; regWrData = 8'h00; tmr0Ovf = 1'b1;
    @(negedge clk); regWrEn = 1'b0; tmr0Ovf = 1'b0; #1;
    chk("R3 set beats write", regRdData, 8'h20);
    wr(8'h00);
  endtask

  task automatic t_service_chain;
    wr(8'h7F);
    stepN(4); chk("R4 no strobe no call", {7'd0, callReq}, 8'h00);
    strobe;
    chk("R5 ext call", {7'd0, callReq}, 8'h01);
    chk("R5 ext vector", callVector, 8'h04);
    stepN(5);
    chk("R6 held", {7'd0, callReq}, 8'h01);
    chk("R6 vector held", callVector, 8'h04);
    ack;
    chk("R7 ack clears ext+me", regRdData, 8'h6E);
    chk("R7 call dropped", {7'd0, callReq}, 8'h00);
    rtn(1'b0); chk("R9 plain return", regRdData, 8'h6E);
    rtn(1'b1); chk("R8 reti sets me", regRdData, 8'h6F);
    strobe; chk("R5 t0 vector", callVector, 8'h08);
    ack; chk("R7 ack clears t0", regRdData, 8'h4E);
    rtn(1'b1); strobe; chk("R5 t1 vector", callVector, 8'h0C);
    ack; chk("R7 ack clears t1", regRdData, 8'h0E);
  endtask

  task automatic t_stack;
    stackFull = 1'b1;
    wr(8'h1F); strobe;
    chk("R4 stack full blocks", {7'd0, callReq}, 8'h00);
    stackFull = 1'b0; strobe;
    chk("R4 stack free call", {7'd0, callReq}, 8'h01);
  endtask

  task automatic t_withdraw;
    wr(8'h1E); chk("R6 withdrawn", {7'd0, callReq}, 8'h00);
    wr(8'h1F); stepN(2); chk("R6 stays withdrawn", {7'd0, callReq}, 8'h00);
    strobe; chk("R6 re-raised on strobe", callVector, 8'h04);
    ack;
  endtask

  task automatic t_enables;
    wr(8'h71); strobe; chk("R4 no source enabled", {7'd0, callReq}, 8'h00);
    ack; chk("R7 stray ack ignored", regRdData, 8'h71);
    wr(8'h75); strobe; chk("R5 disabled ext skipped", callVector, 8'h08);
    ack;
  endtask

  task automatic t_between;
    wr(8'h0F);
    pulse(2); stepN(2); pulse(0);
    strobe; chk("R5 between strobes", callVector, 8'h04);
    chk("R5 call up", {7'd0, callReq}, 8'h01);
    ack;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1; #1;
    t_reset;
    t_regmap;
    t_sticky;
    t_service_chain;
    t_stack;
    t_withdraw;
    t_enables;
    t_between;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #200000;
    nChk++; nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule